// File: doc/BRIEF.md
# Banked Register File with Status Word

This block holds the general-purpose integer registers of a processor core together with the status word that steers them. The low registers exist twice in hardware. A privilege flag and a bank flag in the status word pick which of the two physical copies the core sees. The high registers have a single copy and are visible in every mode.

The core reads through two combinational ports and writes through one synchronous port, all in terms of the active view. A separate port reads and writes the copy of the low registers that is not currently active, so that exception entry code can reach the other set. The status word takes a full-word write and per-flag updates for four condition flags. A change of the effective bank needs no copying: the read multiplexers switch to the other copy on the very next access.

Top module: `bankreg_file`

## Requirements
- R1: After reset every register reads zero on both read ports and through the alternate port, and the status word reads `RST_MD` at bit 30 and `RST_RB` at bit 29 with all other bits zero (0x6000_0000 by default).
- R2: Registers below `NUM_BANKED` come from the active copy. Registers from `NUM_BANKED` to `NUM_REGS-1` have one copy, which every bank setting reads and writes.
- R3: The active bank is bit 29 (bank) AND bit 30 (privilege) of the status word. With bit 30 clear, copy 0 is active whatever bit 29 holds.
- R4: A full-word status write that changes the active bank makes both read ports show the other copy in the cycle after the write edge, with no stall cycle.
- R5: The alternate port always reads and writes the copy that is not active. Its writes do not change anything the main read ports return until the bank is switched.
- R6: The flag inputs update one status bit each: index 0 is bit 0, index 1 is bit 1, index 2 is bit 8 and index 3 is bit 9. Every other status bit keeps its value.
- R7: Status bits other than 0, 1, 4 to 7, 8, 9, 28, 29 and 30 always read zero, and writes to them have no effect (used-bit mask 0x7000_03F3).
- R8: A register write in the same cycle as a status write that changes the bank lands in the copy that was active before that edge.
- R9: When a full-word status write and flag updates occur in the same cycle, the full-word write decides the whole status word.
- R10: A read in the same cycle as a write to that register returns the old contents. The new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | IDX_W | Register index for read port A |
| rd_a_data | output | DATA_W | Read port A data, active view |
| rd_b_idx | input | IDX_W | Register index for read port B |
| rd_b_data | output | DATA_W | Read port B data, active view |
| wr_en | input | 1 | Write enable for the active view |
| wr_idx | input | IDX_W | Write register index |
| wr_data | input | DATA_W | Write data |
| alt_idx | input | BIDX_W | Index into the inactive copy of the low registers |
| alt_rd_data | output | DATA_W | Data read from the inactive copy |
| alt_wr_en | input | 1 | Write enable for the inactive copy |
| alt_wr_data | input | DATA_W | Write data for the inactive copy |
| sr_wr_en | input | 1 | Full-word status write enable |
| sr_wr_data | input | 32 | Full-word status write data |
| flag_en | input | 4 | Per-flag update enables (0: bit 0, 1: bit 1, 2: bit 8, 3: bit 9) |
| flag_val | input | 4 | Per-flag new values |
| sr_q | output | 32 | Current status word |
| act_bank | output | 1 | Copy of the low registers currently active |

## Verification
A status word holding the wrong bank or privilege bit shows at once on the read ports: every low register returns the other copy's contents in the very next cycle, and the alternate port returns the active one. The bench therefore fills the two copies with different values so that every wrong choice is visible. A write sent to the wrong copy stays hidden until that copy is read, so each test reads through both the main ports and the alternate port, and switches the bank, before it moves on. A flag update that disturbs a neighbouring bit shows in the status word one cycle after the edge, and the bench compares the whole word there.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   // Status word layout; bit positions are decoded by neighbouring logic
   localparam int SR_W        = 32;
   localparam int SR_T        = 0;
   localparam int SR_S        = 1;
   localparam int SR_IMASK_LO = 4;
   localparam int SR_IMASK_HI = 7;
   localparam int SR_Q        = 8;
   localparam int SR_M        = 9;
   localparam int SR_BL       = 28;
   localparam int SR_RB       = 29;
   localparam int SR_MD       = 30;

   localparam int NUM_FLAGS   = 4;

   typedef enum logic [1:0] {
      FLAG_T = 2'd0,
      FLAG_S = 2'd1,
      FLAG_Q = 2'd2,
      FLAG_M = 2'd3
   } flag_sel_e;

   function automatic int flag_pos(input int k);
      int p;
      case (k)
         int'(FLAG_T): p = SR_T;
         int'(FLAG_S): p = SR_S;
         int'(FLAG_Q): p = SR_Q;
         default:      p = SR_M;
      endcase
      return p;
   endfunction

   function automatic logic [SR_W-1:0] build_used_mask();
      logic [SR_W-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_FLAGS; k++) m[flag_pos(k)] = 1'b1;
      for (int i = SR_IMASK_LO; i <= SR_IMASK_HI; i++) m[i] = 1'b1;
      m[SR_BL] = 1'b1;
      m[SR_RB] = 1'b1;
      m[SR_MD] = 1'b1;
      return m;
   endfunction

   localparam logic [SR_W-1:0] SR_USED_MASK = build_used_mask();

   function automatic logic [SR_W-1:0] flag_mask();
      logic [SR_W-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_FLAGS; k++) m[flag_pos(k)] = 1'b1;
      return m;
   endfunction

   localparam logic [SR_W-1:0] SR_FLAG_MASK = flag_mask();

   // Bank flag counts only in privileged mode
   function automatic logic eff_bank_of(input logic [SR_W-1:0] sr);
      return sr[SR_MD] & sr[SR_RB];
   endfunction

endpackage

// File: rtl/bankreg_status.sv
module bankreg_status
   import bankreg_pkg::*;
#(
   parameter logic RST_MD = 1'b1,
   parameter logic RST_RB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SR_W-1:0]      wr_data,
   input  logic [NUM_FLAGS-1:0] flag_en,
   input  logic [NUM_FLAGS-1:0] flag_val,
   output logic [SR_W-1:0]      sr_q,
   output logic                 eff_bank
);

   localparam logic [SR_W-1:0] RST_WORD =
      (SR_W'(RST_MD) << SR_MD) | (SR_W'(RST_RB) << SR_RB);

   logic [SR_W-1:0] sr_d;

   always_comb begin
      if (wr_en) begin
         // Full-word write wins over flag updates
         sr_d = wr_data & SR_USED_MASK;
      end else begin
         sr_d = sr_q;
         for (int k = 0; k < NUM_FLAGS; k++) begin
            if (flag_en[k]) sr_d[flag_pos(k)] = flag_val[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= RST_WORD;
      else        sr_q <= sr_d;
   end

   assign eff_bank = eff_bank_of(sr_q);

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
   parameter int DATA_W     = 32,
   parameter int NUM_REGS   = 16,
   parameter int NUM_BANKED = 8,
   localparam int IDX_W      = $clog2(NUM_REGS),
   localparam int BIDX_W     = $clog2(NUM_BANKED),
   localparam int NUM_SHARED = NUM_REGS - NUM_BANKED
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [DATA_W-1:0]                     wr_data,
   input  logic                                  cur_bank,
   input  logic                                  alt_wr_en,
   input  logic [BIDX_W-1:0]                     alt_idx,
   input  logic [DATA_W-1:0]                     alt_data,
   output logic [1:0][NUM_BANKED-1:0][DATA_W-1:0] banked_q,
   output logic [NUM_SHARED-1:0][DATA_W-1:0]     shared_q
);

   for (genvar b = 0; b < 2; b++) begin : g_copy
      for (genvar i = 0; i < NUM_BANKED; i++) begin : g_reg
         logic              view_hit;
         logic              alt_hit;
         logic [DATA_W-1:0] q;

         // Bank comes from the registered status word, so a write in the
         // same cycle as a bank change lands in the previously active copy
         assign view_hit = wr_en && (wr_idx == IDX_W'(i)) && (cur_bank == 1'(b));
         assign alt_hit  = alt_wr_en && (alt_idx == BIDX_W'(i)) && (cur_bank != 1'(b));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (view_hit) q <= wr_data;
            else if (alt_hit)  q <= alt_data;
         end

         assign banked_q[b][i] = q;
      end
   end

   for (genvar j = 0; j < NUM_SHARED; j++) begin : g_shared
      logic              hit;
      logic [DATA_W-1:0] q;

      assign hit = wr_en && (wr_idx == IDX_W'(NUM_BANKED + j));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= wr_data;
      end

      assign shared_q[j] = q;
   end

endmodule

// File: rtl/bankreg_rdport.sv
module bankreg_rdport #(
   parameter int DATA_W     = 32,
   parameter int NUM_REGS   = 16,
   parameter int NUM_BANKED = 8,
   localparam int IDX_W      = $clog2(NUM_REGS),
   localparam int NUM_SHARED = NUM_REGS - NUM_BANKED
) (
   input  logic [IDX_W-1:0]                      idx,
   input  logic                                  bank,
   input  logic [1:0][NUM_BANKED-1:0][DATA_W-1:0] banked_q,
   input  logic [NUM_SHARED-1:0][DATA_W-1:0]     shared_q,
   output logic [DATA_W-1:0]                     data
);

   always_comb begin
      data = '0;
      for (int i = 0; i < NUM_BANKED; i++) begin
         if (idx == IDX_W'(i)) data = banked_q[bank][i];
      end
      for (int j = 0; j < NUM_SHARED; j++) begin
         if (idx == IDX_W'(NUM_BANKED + j)) data = shared_q[j];
      end
   end

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int   DATA_W     = 32,
   parameter int   NUM_REGS   = 16,
   parameter int   NUM_BANKED = 8,
   parameter logic RST_MD     = 1'b1,
   parameter logic RST_RB     = 1'b1,
   localparam int  IDX_W      = $clog2(NUM_REGS),
   localparam int  BIDX_W     = $clog2(NUM_BANKED)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_a_idx,
   output logic [DATA_W-1:0]    rd_a_data,
   input  logic [IDX_W-1:0]     rd_b_idx,
   output logic [DATA_W-1:0]    rd_b_data,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [BIDX_W-1:0]    alt_idx,
   output logic [DATA_W-1:0]    alt_rd_data,
   input  logic                 alt_wr_en,
   input  logic [DATA_W-1:0]    alt_wr_data,
   input  logic                 sr_wr_en,
   input  logic [31:0]          sr_wr_data,
   input  logic [3:0]           flag_en,
   input  logic [3:0]           flag_val,
   output logic [31:0]          sr_q,
   output logic                 act_bank
);

   localparam int NUM_SHARED = NUM_REGS - NUM_BANKED;

   // Elaboration-time parameter checks
   if (NUM_BANKED < 2 || (1 << BIDX_W) != NUM_BANKED) begin : g_bad_banked
      $error("NUM_BANKED must be a power of two of at least 2");
   end
   if (NUM_SHARED < 1) begin : g_bad_regs
      $error("NUM_REGS must exceed NUM_BANKED");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end
   if (NUM_FLAGS != 4 || SR_W != 32) begin : g_bad_pkg
      $error("status layout does not match the port widths");
   end

   logic                                  cur_bank;
   logic [1:0][NUM_BANKED-1:0][DATA_W-1:0] banked_q;
   logic [NUM_SHARED-1:0][DATA_W-1:0]     shared_q;

   bankreg_status #(
      .RST_MD (RST_MD),
      .RST_RB (RST_RB)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sr_wr_en),
      .wr_data  (sr_wr_data),
      .flag_en  (flag_en),
      .flag_val (flag_val),
      .sr_q     (sr_q),
      .eff_bank (cur_bank)
   );

   bankreg_store #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .NUM_BANKED (NUM_BANKED)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .cur_bank  (cur_bank),
      .alt_wr_en (alt_wr_en),
      .alt_idx   (alt_idx),
      .alt_data  (alt_wr_data),
      .banked_q  (banked_q),
      .shared_q  (shared_q)
   );

   bankreg_rdport #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .NUM_BANKED (NUM_BANKED)
   ) u_rd_a (
      .idx      (rd_a_idx),
      .bank     (cur_bank),
      .banked_q (banked_q),
      .shared_q (shared_q),
      .data     (rd_a_data)
   );

   bankreg_rdport #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .NUM_BANKED (NUM_BANKED)
   ) u_rd_b (
      .idx      (rd_b_idx),
      .bank     (cur_bank),
      .banked_q (banked_q),
      .shared_q (shared_q),
      .data     (rd_b_data)
   );

   // Alternate port: same selector, opposite copy, index limited to banked range
   bankreg_rdport #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .NUM_BANKED (NUM_BANKED)
   ) u_rd_alt (
      .idx      (IDX_W'(alt_idx)),
      .bank     (~cur_bank),
      .banked_q (banked_q),
      .shared_q (shared_q),
      .data     (alt_rd_data)
   );

   assign act_bank = cur_bank;

endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
   import bankreg_pkg::*;
#(
   parameter int  DATA_W     = 32,
   parameter int  NUM_REGS   = 16,
   parameter int  NUM_BANKED = 8,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              sr_wr_en,
   input logic [31:0]       sr_wr_data,
   input logic [3:0]        flag_en,
   input logic [31:0]       sr_q,
   input logic              act_bank
);

   p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_q & ~SR_USED_MASK) == '0);

   p_user_bank0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_q[SR_MD] |-> !act_bank);

   p_full_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_en |=> sr_q == ($past(sr_wr_data) & SR_USED_MASK));

   p_flag_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_wr_en && flag_en != '0) |=>
         (sr_q & ~SR_FLAG_MASK) == ($past(sr_q) & ~SR_FLAG_MASK));

   p_sr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_wr_en && flag_en == '0) |=> $stable(sr_q));

   // Alternate-port writes never disturb the active view
   p_read_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !sr_wr_en) |=>
         (rd_a_idx != $past(rd_a_idx)) || $stable(rd_a_data));

   p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sr_wr_en) |=>
         (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data)));

endmodule

bind bankreg_file bankreg_file_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .NUM_BANKED (NUM_BANKED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .sr_wr_en   (sr_wr_en),
   .sr_wr_data (sr_wr_data),
   .flag_en    (flag_en),
   .sr_q       (sr_q),
   .act_bank   (act_bank)
);

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  alt_idx = '0;
   logic [31:0] alt_rd_data, alt_wr_data = '0;
   logic        alt_wr_en = 1'b0;
   logic        sr_wr_en = 1'b0;
   logic [31:0] sr_wr_data = '0;
   logic [3:0]  flag_en = '0, flag_val = '0;
   logic [31:0] sr_q;
   logic        act_bank;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bankreg_file u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .alt_idx(alt_idx), .alt_rd_data(alt_rd_data),
      .alt_wr_en(alt_wr_en), .alt_wr_data(alt_wr_data),
      .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
      .flag_en(flag_en), .flag_val(flag_val),
      .sr_q(sr_q), .act_bank(act_bank)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wreg(input int idx, input logic [31:0] d);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic wsr(input logic [31:0] d);
      sr_wr_en = 1'b1; sr_wr_data = d;
      tick();
      sr_wr_en = 1'b0;
   endtask

   task automatic chk_reg(input int idx, input logic [31:0] exp, input string tag);
      rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
      #1;
      check(rd_a_data == exp, tag, rd_a_data, exp);
      check(rd_b_data == exp, tag, rd_b_data, exp);
   endtask

   task automatic chk_alt(input int idx, input logic [31:0] exp, input string tag);
      alt_idx = 3'(idx);
      #1;
      check(alt_rd_data == exp, tag, alt_rd_data, exp);
   endtask

   task automatic t_reset();
      check(sr_q == 32'h6000_0000, "R1 status after reset", sr_q, 32'h6000_0000);
      check(act_bank == 1'b1, "R1 active bank after reset", 32'(act_bank), 32'd1);
      for (int i = 0; i < 16; i++) chk_reg(i, 32'h0, "R1 register after reset");
      for (int i = 0; i < 8; i++)  chk_alt(i, 32'h0, "R1 alternate after reset");
   endtask

   task automatic t_fill();
      for (int i = 0; i < 16; i++) wreg(i, 32'hA000_0000 + 32'(i));
      for (int i = 0; i < 16; i++) chk_reg(i, 32'hA000_0000 + 32'(i), "R2 fill copy 1");
      chk_alt(4, 32'h0, "R5 other copy untouched by fill");
   endtask

   task automatic t_switch();
      wsr(32'h4000_0000);
      check(act_bank == 1'b0, "R3 privileged bank 0", 32'(act_bank), 32'd0);
      chk_reg(0, 32'h0, "R4 copy 0 visible next cycle");
      chk_reg(7, 32'h0, "R4 copy 0 visible next cycle");
      chk_reg(8, 32'hA000_0008, "R2 shared register in copy 0 view");
      chk_reg(15, 32'hA000_000F, "R2 shared register in copy 0 view");
      wreg(3, 32'h0000_00B3);
      wreg(12, 32'h0000_00BC);
      wsr(32'h2000_0000);
      check(act_bank == 1'b0, "R3 user mode ignores bank flag", 32'(act_bank), 32'd0);
      chk_reg(3, 32'h0000_00B3, "R3 user mode reads copy 0");
      wsr(32'h6000_0000);
      chk_reg(3, 32'hA000_0003, "R4 switch back to copy 1");
      chk_reg(12, 32'h0000_00BC, "R2 shared write seen in copy 1 view");
   endtask

   task automatic t_alt();
      wsr(32'h2000_0000);
      chk_alt(3, 32'hA000_0003, "R5 alternate reads copy 1 in user mode");
      alt_wr_en = 1'b1; alt_idx = 3'd5; alt_wr_data = 32'h0000_00C5;
      tick();
      alt_wr_en = 1'b0;
      chk_reg(5, 32'h0, "R5 alternate write hidden from active view");
      chk_alt(5, 32'h0000_00C5, "R5 alternate write read back");
      wsr(32'h6000_0000);
      chk_reg(5, 32'h0000_00C5, "R5 alternate write visible after switch");
      chk_alt(3, 32'h0000_00B3, "R5 alternate now reads copy 0");
   endtask

   task automatic t_same_cycle();
      wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h0000_00D2;
      sr_wr_en = 1'b1; sr_wr_data = 32'h4000_0000;
      tick();
      wr_en = 1'b0; sr_wr_en = 1'b0;
      chk_reg(2, 32'h0, "R8 copy 0 not written");
      chk_alt(2, 32'h0000_00D2, "R8 write landed in old copy 1");
   endtask

   task automatic t_flags();
      wsr(32'h7000_00F3);
      check(sr_q == 32'h7000_00F3, "R6 start word", sr_q, 32'h7000_00F3);
      flag_en = 4'b0001; flag_val = 4'b0000;
      tick();
      flag_en = '0;
      check(sr_q == 32'h7000_00F2, "R6 clear bit 0", sr_q, 32'h7000_00F2);
      flag_en = 4'b1000; flag_val = 4'b1000;
      tick();
      flag_en = '0;
      check(sr_q == 32'h7000_02F2, "R6 set bit 9", sr_q, 32'h7000_02F2);
      flag_en = 4'b0110; flag_val = 4'b0100;
      tick();
      flag_en = '0;
      check(sr_q == 32'h7000_03F0, "R6 set bit 8 clear bit 1", sr_q, 32'h7000_03F0);
      check(act_bank == 1'b1, "R6 bank unchanged by flags", 32'(act_bank), 32'd1);
   endtask

   task automatic t_unused();
      wsr(32'hFFFF_FFFF);
      check(sr_q == 32'h7000_03F3, "R7 unused bits read zero", sr_q, 32'h7000_03F3);
      wsr(32'h8FFF_FC0C);
      check(sr_q == 32'h0, "R7 writes to unused bits ignored", sr_q, 32'h0);
   endtask

   task automatic t_priority();
      wsr(32'h4000_0000);
      sr_wr_en = 1'b1; sr_wr_data = 32'h4000_0000;
      flag_en = 4'b1111; flag_val = 4'b1111;
      tick();
      sr_wr_en = 1'b0; flag_en = '0;
      check(sr_q == 32'h4000_0000, "R9 full write beats flags", sr_q, 32'h4000_0000);
   endtask

   task automatic t_rdw();
      wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h0000_00E9;
      rd_a_idx = 4'd9; rd_b_idx = 4'd9;
      #1;
      check(rd_a_data == 32'hA000_0009, "R10 old value before edge", rd_a_data, 32'hA000_0009);
      tick();
      wr_en = 1'b0;
      chk_reg(9, 32'h0000_00E9, "R10 new value after edge");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick();
      tick();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_fill();
      t_switch();
      t_alt();
      t_same_cycle();
      t_flags();
      t_unused();
      t_priority();
      t_rdw();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule